// File: doc/BRIEF.md
# Audio Serial Clock Ratio Monitor

This block supervises the two clocks of a serial audio port: the bit clock and the frame sync. It counts the bit-clock rising edges between consecutive frame-start edges and maps that count onto a small set of accepted ratios, reporting a 4-bit ratio code. It also measures each frame's length against a free-running reference clock. It classifies the frame rate into a sample-rate family and, unless rate checking is switched off, compares the family with the configured 3-bit rate code.

Whenever the ratio or the rate is not acceptable, the block holds a ramp-down request so that the playback path can fade to silence. When both become acceptable again, it drops that request and issues a one-cycle resume pulse, so that the playback path can ramp back to its configured volume. The bit clock and frame sync are taken in through synchronizer flops, and all logic runs on the reference clock.

Top module: `clk_ratio_monitor`

## Requirements
- R1: A frame is the span between two start edges of `fsync`: a falling edge when `start_on_fall` = 1 and a rising edge when it is 0. The edge of the other direction is ignored. The frame's size is the number of `bclk` rising edges inside that span.
- R2: A frame of 64, 96, 128, 192, 256, 384 or 512 bit clocks gives a `ratio_code` of 0x4, 0x5, 0x6, 0x7, 0x8, 0x9 or 0xA respectively.
- R3: Any other frame size gives `ratio_code` 0xF. The output only ever shows codes 0x4 to 0xA or 0xF.
- R4: A ratio code other than 0xF is shown only after two back-to-back frames of the same accepted size. A single frame of a different size, accepted or not, turns the code to 0xF at the start edge that closes that frame.
- R5: When 1024 `bclk` rising edges pass without a start edge, `ratio_code` becomes 0xF. The first frame after that is discarded, so two more full frames are needed before the code becomes valid again.
- R6: Taking P = `REF_PER_FRAME_48` reference cycles, the rate families have nominal frame lengths 3P (code 001), 3P/2 (011), P (100), P/2 (101) and P/4 (110). A frame of nominal length N is given that family's code when its length lies between N−N/25 and N+17N/128, a window that covers both the 48 kHz and the 44.1 kHz members with about 4 % margin. Otherwise the frame gets code 000. `rate_code` also falls to 000 when no start edge arrives within the upper limit of the 001 window.
- R7: With `auto_rate_off` = 0, a rate fault exists unless `rate_code` equals `rate_cfg` and is not 000. A reserved `rate_cfg` (000, 010, 111) is therefore always a fault. With `auto_rate_off` = 1, the rate is not checked.
- R8: `ramp_down` is high in the cycle after any ratio or rate fault. On the first cycle with no fault, it falls together with a single-cycle `ramp_up` pulse.
- R9: During and right after reset, `ratio_code` is 0xF, `rate_code` is 000, `ramp_down` is 1 and `ramp_up` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk | input | 1 | Serial bit clock, asynchronous |
| fsync | input | 1 | Frame sync, asynchronous |
| start_on_fall | input | 1 | 1: frames start on the falling edge of fsync; 0: on the rising edge |
| auto_rate_off | input | 1 | 1 disables the rate check |
| rate_cfg | input | 3 | Configured sample-rate family code |
| ratio_code | output | 4 | Detected bit-clock-per-frame code |
| rate_code | output | 3 | Detected sample-rate family code |
| ramp_down | output | 1 | Fade request while any fault exists |
| ramp_up | output | 1 | One-cycle resume pulse |

## Verification
An input edge passes through two synchronizer flops. It is then registered in the frame meter, which puts the new verdict into `ratio_code` and `rate_code` four reference edges after the edge was driven. `ramp_down` and `ramp_up` follow one edge after that. A configuration change reaches the handshake one edge after it is applied. Each scoreboard entry is pushed at least four falling edges after the stimulus that decides it, and usually a full frame later. The stream is arranged so that the frame being judged was closed by a start edge one whole frame before the sample, which leaves every result stable while it is compared. Resume pulses are counted at each falling edge, and each entry compares the number of pulses seen since the previous entry.

// File: rtl/crm_pkg.sv
package crm_pkg;

    typedef logic [3:0] ratio_code_t;

    localparam ratio_code_t RATIO_BAD = 4'hF;
    localparam int          NFAM      = 5;

    typedef enum logic [2:0] {
        RATE_NONE = 3'b000,
        RATE_16K  = 3'b001,
        RATE_32K  = 3'b011,
        RATE_48K  = 3'b100,
        RATE_96K  = 3'b101,
        RATE_192K = 3'b110
    } rate_code_t;

    typedef struct packed {
        ratio_code_t code;
        logic        ok;
    } ratio_verdict_t;

    function automatic ratio_code_t encode_ratio(input int unsigned n);
        case (n)
            64:      return 4'h4;
            96:      return 4'h5;
            128:     return 4'h6;
            192:     return 4'h7;
            256:     return 4'h8;
            384:     return 4'h9;
            512:     return 4'hA;
            default: return RATIO_BAD;
        endcase
    endfunction

    function automatic rate_code_t fam_code(input int i);
        case (i)
            0:       return RATE_16K;
            1:       return RATE_32K;
            2:       return RATE_48K;
            3:       return RATE_96K;
            default: return RATE_192K;
        endcase
    endfunction

    function automatic int unsigned fam_nominal(input int unsigned p48, input int i);
        case (i)
            0:       return p48 * 3;
            1:       return (p48 * 3) / 2;
            2:       return p48;
            3:       return p48 / 2;
            default: return p48 / 4;
        endcase
    endfunction

    function automatic int unsigned win_lo(input int unsigned n);
        return n - n / 25;
    endfunction

    function automatic int unsigned win_hi(input int unsigned n);
        return n + (n * 17) / 128;
    endfunction

endpackage

// File: rtl/crm_edge_sync.sv
module crm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic now_q,
    output logic was_q
);
    logic [STAGES:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) shreg <= '0;
        else     shreg <= {shreg[STAGES-1:0], din};
    end

    assign now_q = shreg[STAGES-1];
    assign was_q = shreg[STAGES];
endmodule

// File: rtl/crm_frame_meter.sv
module crm_frame_meter #(
    parameter int          BIT_W     = 11,
    parameter int          REF_W     = 14,
    parameter int unsigned BIT_LIMIT = 1024,
    parameter int unsigned REF_LIMIT = 10440
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bclk_rise,
    input  logic             frame_start,
    output logic             frame_done,
    output logic [BIT_W-1:0] bit_count,
    output logic [REF_W-1:0] ref_count,
    output logic             bit_timeout,
    output logic             ref_timeout
);
    localparam logic [BIT_W-1:0] BIT_SAT = BIT_W'(BIT_LIMIT);
    localparam logic [REF_W-1:0] REF_SAT = REF_W'(REF_LIMIT);

    logic [BIT_W-1:0] bit_run;
    logic [REF_W-1:0] ref_run;
    logic             primed;
    logic             bit_gone;
    logic             ref_gone;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_run     <= '0;
            ref_run     <= '0;
            primed      <= 1'b0;
            bit_gone    <= 1'b0;
            ref_gone    <= 1'b0;
            frame_done  <= 1'b0;
            bit_count   <= '0;
            ref_count   <= '0;
            bit_timeout <= 1'b0;
            ref_timeout <= 1'b0;
        end else begin
            frame_done  <= 1'b0;
            bit_timeout <= 1'b0;
            ref_timeout <= 1'b0;
            if (frame_start) begin
                bit_count  <= bit_run;
                ref_count  <= ref_run;
                frame_done <= primed;
                primed     <= 1'b1;
                bit_run    <= {{(BIT_W-1){1'b0}}, bclk_rise};
                ref_run    <= {{(REF_W-1){1'b0}}, 1'b1};
                bit_gone   <= 1'b0;
                ref_gone   <= 1'b0;
            end else begin
                if (bclk_rise && bit_run != BIT_SAT) bit_run <= bit_run + 1'b1;
                if (ref_run != REF_SAT)              ref_run <= ref_run + 1'b1;
                if (bit_run == BIT_SAT && !bit_gone) begin
                    bit_timeout <= 1'b1;
                    bit_gone    <= 1'b1;
                    primed      <= 1'b0;
                end
                if (ref_run == REF_SAT && !ref_gone) begin
                    ref_timeout <= 1'b1;
                    ref_gone    <= 1'b1;
                    primed      <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/crm_ratio_judge.sv
module crm_ratio_judge
    import crm_pkg::*;
#(
    parameter int BIT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_done,
    input  logic [BIT_W-1:0] bit_count,
    input  logic             bit_timeout,
    output ratio_verdict_t   verdict
);
    ratio_code_t cand;
    logic        cand_v;
    ratio_code_t enc;

    assign enc = encode_ratio(32'(bit_count));

    always_ff @(posedge clk) begin
        if (rst) begin
            cand         <= RATIO_BAD;
            cand_v       <= 1'b0;
            verdict.code <= RATIO_BAD;
            verdict.ok   <= 1'b0;
        end else if (bit_timeout) begin
            cand_v       <= 1'b0;
            verdict.code <= RATIO_BAD;
            verdict.ok   <= 1'b0;
        end else if (frame_done) begin
            if (enc == RATIO_BAD) begin
                cand_v       <= 1'b0;
                verdict.code <= RATIO_BAD;
                verdict.ok   <= 1'b0;
            end else if (cand_v && cand == enc) begin
                verdict.code <= enc;
                verdict.ok   <= 1'b1;
            end else begin
                cand         <= enc;
                cand_v       <= 1'b1;
                verdict.code <= RATIO_BAD;
                verdict.ok   <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/crm_rate_judge.sv
module crm_rate_judge
    import crm_pkg::*;
#(
    parameter int          REF_W = 14,
    parameter int unsigned P48   = 3072
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_done,
    input  logic [REF_W-1:0] ref_count,
    input  logic             ref_timeout,
    input  logic             auto_off,
    input  logic [2:0]       rate_cfg,
    output logic [2:0]       rate_code,
    output logic             rate_ok
);
    logic [NFAM-1:0] hit;
    rate_code_t      det;
    rate_code_t      det_q;

    for (genvar g = 0; g < NFAM; g++) begin : g_fam
        localparam int unsigned    NOM = fam_nominal(P48, g);
        localparam logic [REF_W-1:0] LO = REF_W'(win_lo(NOM));
        localparam logic [REF_W-1:0] HI = REF_W'(win_hi(NOM));
        assign hit[g] = (ref_count >= LO) && (ref_count <= HI);
    end

    always_comb begin
        det = RATE_NONE;
        for (int i = 0; i < NFAM; i++) begin
            if (hit[i]) det = fam_code(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)              det_q <= RATE_NONE;
        else if (ref_timeout) det_q <= RATE_NONE;
        else if (frame_done)  det_q <= det;
    end

    assign rate_code = det_q;
    assign rate_ok   = auto_off || (det_q == rate_code_t'(rate_cfg) && det_q != RATE_NONE);
endmodule

// File: rtl/clk_ratio_monitor.sv
module clk_ratio_monitor
    import crm_pkg::*;
#(
    parameter int unsigned REF_PER_FRAME_48 = 3072,
    parameter int unsigned TIMEOUT_BITS     = 1024,
    parameter int          SYNC_STAGES      = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bclk,
    input  logic       fsync,
    input  logic       start_on_fall,
    input  logic       auto_rate_off,
    input  logic [2:0] rate_cfg,
    output logic [3:0] ratio_code,
    output logic [2:0] rate_code,
    output logic       ramp_down,
    output logic       ramp_up
);
    localparam int unsigned REF_LIMIT = win_hi(fam_nominal(REF_PER_FRAME_48, 0));
    localparam int          BIT_W     = $clog2(TIMEOUT_BITS + 1);
    localparam int          REF_W     = $clog2(REF_LIMIT + 1);

    logic [1:0] raw_in;
    logic [1:0] now_v;
    logic [1:0] was_v;

    assign raw_in = {fsync, bclk};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        crm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst   (rst),
            .din   (raw_in[g]),
            .now_q (now_v[g]),
            .was_q (was_v[g])
        );
    end

    logic bclk_rise;
    logic frame_start;

    assign bclk_rise   = now_v[0] && !was_v[0];
    assign frame_start = (now_v[1] != was_v[1]) && (now_v[1] != start_on_fall);

    logic             frame_done;
    logic [BIT_W-1:0] bit_count;
    logic [REF_W-1:0] ref_count;
    logic             bit_timeout;
    logic             ref_timeout;

    crm_frame_meter #(
        .BIT_W     (BIT_W),
        .REF_W     (REF_W),
        .BIT_LIMIT (TIMEOUT_BITS),
        .REF_LIMIT (REF_LIMIT)
    ) u_meter (
        .clk         (clk),
        .rst         (rst),
        .bclk_rise   (bclk_rise),
        .frame_start (frame_start),
        .frame_done  (frame_done),
        .bit_count   (bit_count),
        .ref_count   (ref_count),
        .bit_timeout (bit_timeout),
        .ref_timeout (ref_timeout)
    );

    ratio_verdict_t rv;

    crm_ratio_judge #(.BIT_W(BIT_W)) u_ratio (
        .clk         (clk),
        .rst         (rst),
        .frame_done  (frame_done),
        .bit_count   (bit_count),
        .bit_timeout (bit_timeout),
        .verdict     (rv)
    );

    logic rate_ok;

    crm_rate_judge #(.REF_W(REF_W), .P48(REF_PER_FRAME_48)) u_rate (
        .clk         (clk),
        .rst         (rst),
        .frame_done  (frame_done),
        .ref_count   (ref_count),
        .ref_timeout (ref_timeout),
        .auto_off    (auto_rate_off),
        .rate_cfg    (rate_cfg),
        .rate_code   (rate_code),
        .rate_ok     (rate_ok)
    );

    logic all_ok;
    logic muted;

    assign all_ok = rv.ok && rate_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            muted   <= 1'b1;
            ramp_up <= 1'b0;
        end else begin
            muted   <= !all_ok;
            ramp_up <= muted && all_ok;
        end
    end

    assign ratio_code = rv.code;
    assign ramp_down  = muted;
endmodule

// File: rtl/clk_ratio_monitor_chk.sv
module clk_ratio_monitor_chk (
    input logic       clk,
    input logic       rst,
    input logic       auto_rate_off,
    input logic [2:0] rate_cfg,
    input logic [3:0] ratio_code,
    input logic [2:0] rate_code,
    input logic       ramp_down,
    input logic       ramp_up
);
    AST_RESET_STATE: assert property (@(posedge clk) rst |=> (ratio_code == 4'hF && rate_code == 3'b000 && ramp_down && !ramp_up)); // R9
    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst) ((ratio_code >= 4'h4 && ratio_code <= 4'hA) || ratio_code == 4'hF)); // R3
    AST_RATE_LEGAL: assert property (@(posedge clk) disable iff (rst) (rate_code != 3'b010 && rate_code != 3'b111)); // R6
    AST_RATIO_GATE: assert property (@(posedge clk) disable iff (rst) !ramp_down |-> $past(ratio_code) != 4'hF); // R4
    AST_RATE_GATE: assert property (@(posedge clk) disable iff (rst) !ramp_down |-> ($past(auto_rate_off) || ($past(rate_code) == $past(rate_cfg) && $past(rate_code) != 3'b000))); // R7
    AST_UP_SINGLE: assert property (@(posedge clk) disable iff (rst) ramp_up |=> !ramp_up); // R8
    AST_UP_FROM_DOWN: assert property (@(posedge clk) disable iff (rst) ramp_up |-> (!ramp_down && $past(ramp_down))); // R8
endmodule

bind clk_ratio_monitor clk_ratio_monitor_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .auto_rate_off (auto_rate_off),
    .rate_cfg      (rate_cfg),
    .ratio_code    (ratio_code),
    .rate_code     (rate_code),
    .ramp_down     (ramp_down),
    .ramp_up       (ramp_up)
);

// File: tb/sim_clk_ratio_monitor.sv
module sim_clk_ratio_monitor;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bclk = 1'b0;
    logic       fsync = 1'b1;
    logic       start_on_fall = 1'b1;
    logic       auto_rate_off = 1'b0;
    logic [2:0] rate_cfg = 3'b100;
    logic [3:0] ratio_code;
    logic [2:0] rate_code;
    logic       ramp_down;
    logic       ramp_up;

    always #10 clk = ~clk;

    clk_ratio_monitor u0 (
        .clk           (clk),
        .rst           (rst),
        .bclk          (bclk),
        .fsync         (fsync),
        .start_on_fall (start_on_fall),
        .auto_rate_off (auto_rate_off),
        .rate_cfg      (rate_cfg),
        .ratio_code    (ratio_code),
        .rate_code     (rate_code),
        .ramp_down     (ramp_down),
        .ramp_up       (ramp_up)
    );

    typedef struct {
        string      tag;
        logic [3:0] ratio;
        logic [2:0] rate;
        logic       down;
        int         ups;
    } exp_t;

    exp_t q[$];
    exp_t e;
    int   n_chk = 0;
    int   n_fail = 0;
    int   ups_total = 0;
    int   ups_mark = 0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // monitor: counts resume pulses and pops scoreboard items
    always @(negedge clk) begin
        if (ramp_up) ups_total++;
        while (q.size() > 0) begin
            e = q.pop_front();
            chk(e.tag, "ratio_code", int'(ratio_code), int'(e.ratio));
            chk(e.tag, "rate_code", int'(rate_code), int'(e.rate));
            chk(e.tag, "ramp_down", int'(ramp_down), int'(e.down));
            chk(e.tag, "ramp_up pulses", ups_total - ups_mark, e.ups);
            ups_mark = ups_total;
        end
    end

    task automatic expect_now(input string tag, input logic [3:0] r, input logic [2:0] rt,
                              input logic d, input int u);
        exp_t it;
        repeat (4) @(negedge clk);
        it.tag = tag; it.ratio = r; it.rate = rt; it.down = d; it.ups = u;
        q.push_back(it);
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // one frame = ratio bits, each bit hp cycles low then hp cycles high
    task automatic frames(input int ratio, input int hp, input int n);
        logic lvl;
        lvl = start_on_fall ? 1'b0 : 1'b1;
        for (int f = 0; f < n; f++) begin
            for (int b = 0; b < ratio; b++) begin
                @(negedge clk);
                bclk  = 1'b0;
                fsync = (b < ratio / 2) ? lvl : ~lvl;
                repeat (hp - 1) @(negedge clk);
                @(negedge clk);
                bclk = 1'b1;
                repeat (hp - 1) @(negedge clk);
            end
        end
    endtask

    task automatic bits_only(input int nbits, input int hp);
        for (int b = 0; b < nbits; b++) begin
            @(negedge clk);
            bclk = 1'b0;
            repeat (hp - 1) @(negedge clk);
            @(negedge clk);
            bclk = 1'b1;
            repeat (hp - 1) @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual run still busy, expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        expect_now("R9 reset state", 4'hF, 3'b000, 1'b1, 0);

        frames(64, 24, 3);
        expect_now("R1 R2 R8 ratio 64 at 48k", 4'h4, 3'b100, 1'b0, 1);

        frames(128, 12, 2);
        expect_now("R4 new ratio not yet confirmed", 4'hF, 3'b100, 1'b1, 0);
        frames(128, 12, 1);
        expect_now("R4 R2 ratio 128 confirmed", 4'h6, 3'b100, 1'b0, 1);

        rate_cfg = 3'b011;
        frames(128, 18, 2);
        expect_now("R6 32k family", 4'h6, 3'b011, 1'b0, 1);

        rate_cfg = 3'b001;
        frames(128, 36, 2);
        expect_now("R6 16k family", 4'h6, 3'b001, 1'b0, 1);

        rate_cfg = 3'b100;
        frames(64, 26, 3);
        expect_now("R6 44.1k member of 48k window", 4'h4, 3'b100, 1'b0, 1);

        frames(64, 12, 2);
        expect_now("R7 rate mismatch faults", 4'h4, 3'b101, 1'b1, 0);
        auto_rate_off = 1'b1;
        frames(64, 12, 1);
        expect_now("R7 rate check disabled", 4'h4, 3'b101, 1'b0, 1);

        auto_rate_off = 1'b0;
        rate_cfg = 3'b111;
        frames(64, 24, 2);
        expect_now("R7 reserved rate setting faults", 4'h4, 3'b100, 1'b1, 0);

        rate_cfg = 3'b100;
        frames(100, 15, 2);
        expect_now("R3 unsupported ratio 100", 4'hF, 3'b100, 1'b1, 1);

        frames(64, 24, 3);
        expect_now("R2 recovery to 64", 4'h4, 3'b100, 1'b0, 1);
        bits_only(1100, 2);
        expect_now("R5 missing frame sync timeout", 4'hF, 3'b100, 1'b1, 0);
        frames(64, 24, 2);
        expect_now("R5 R4 first frame after timeout dropped", 4'hF, 3'b100, 1'b1, 0);
        frames(64, 24, 1);
        expect_now("R5 valid again", 4'h4, 3'b100, 1'b0, 1);

        repeat (11000) @(negedge clk);
        expect_now("R6 rate lost without frames", 4'h4, 3'b000, 1'b1, 0);

        start_on_fall = 1'b0;
        fsync = 1'b0;
        do_reset();
        frames(64, 24, 3);
        expect_now("R1 rising start edge", 4'h4, 3'b100, 1'b0, 1);

        rate_cfg = 3'b110;
        frames(96, 4, 3);
        expect_now("R2 ratio 96 at 192k", 4'h5, 3'b110, 1'b0, 1);
        frames(192, 2, 3);
        expect_now("R2 ratio 192 at 192k", 4'h7, 3'b110, 1'b0, 1);
        frames(384, 1, 3);
        expect_now("R2 ratio 384 at 192k", 4'h9, 3'b110, 1'b0, 1);
        rate_cfg = 3'b101;
        frames(256, 3, 3);
        expect_now("R2 ratio 256 at 96k", 4'h8, 3'b101, 1'b0, 1);
        rate_cfg = 3'b100;
        frames(512, 3, 3);
        expect_now("R2 ratio 512 at 48k", 4'hA, 3'b100, 1'b0, 1);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule